// File: doc/BRIEF.md
# Transfer Descriptor Status Updater

This block works out what a host controller writes back into a transfer descriptor once one bus transaction has been tried for it. The caller presents the descriptor's 32-bit control word, its 32-bit token word and the outcome of the transaction. The outcome is either a returned byte count or one of a few response codes. One clock later the block returns the new control word and a three-way verdict for the list walker. The verdict tells the walker to advance the queue, to move on without advancing, or to stop the frame. The block also returns two interrupt-cause bits, two status flags for the controller's status register and a flag saying whether the control word needs writing back.

The token word is also split into its fields: packet identifier, device address, endpoint and maximum length. The caller uses these to run the transaction in the first place. Memory traffic and the bus signalling itself stay with the caller.

Top module: `td_status_unit`

## Requirements
- R1: The token is decoded as follows. `tok_pid` is bits 7:0, `tok_addr` is bits 14:8, `tok_ep` is bits 18:15, and `tok_maxlen` is bits 31:21 plus one, kept to 11 bits (so 0x7FF gives 0).
- R2: A word accepted with `in_valid` high at one rising edge appears on the outputs at that edge, with `out_valid` high for that cycle only. Outputs hold their values while no word is accepted. After reset, `out_valid` and all outputs are zero.
- R3: Control bit 24 (interrupt on completion) always sets `cause[0]`. When control bit 23 (active) is clear, the result is skip (code 1), the control word comes back unchanged and nothing else is raised.
- R4: On an active descriptor, a PID other than SETUP (0x2D), IN (0x69) or OUT (0xE1) raises `set_proc_err`, gives result abort (code 2) and leaves the control word unchanged.
- R5: The response codes are DATA=0, NODEV=1, NAK=2, STALL=3, BABBLE=4 and TIMEOUT=5; codes 6 and 7 act as TIMEOUT. On DATA, bits 10:0 become the length minus one, in 11 bits, and active is cleared. The length is the maximum length for OUT and SETUP, and `rsp_count` for IN. The result is success (code 0).
- R6: An IN whose `rsp_count` exceeds the maximum length is handled as BABBLE, and its length field is left alone.
- R7: An IN on DATA with control bit 29 (short-packet detect) set and a length below the maximum raises `cause[1]` and gives result skip.
- R8: NODEV and TIMEOUT set bit 18. A nonzero error count in bits 28:27 is decremented. If the count reaches zero, active is cleared and `set_usb_err` is raised. The result is skip.
- R9: NAK sets bit 19 and gives skip. A NAK on SETUP additionally takes the R8 path.
- R10: STALL sets bit 22, clears active and gives skip. BABBLE sets bits 20 and 22, clears active and gives abort.
- R11: With control bit 25 (isochronous) set, active is cleared after any attempt with a valid PID, whatever the response.
- R12: `changed` is high exactly when `ctrl_out` differs from the control word that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept a descriptor and outcome this cycle |
| ctrl_in | input | 32 | Descriptor control word |
| token_in | input | 32 | Descriptor token word |
| rsp_code | input | 3 | Transaction outcome code |
| rsp_count | input | CNT_W | Byte count returned on DATA |
| out_valid | output | 1 | Outputs updated this cycle |
| ctrl_out | output | 32 | Updated control word |
| result | output | 2 | 0 success, 1 skip, 2 abort frame |
| cause | output | 2 | Interrupt cause: bit0 completion, bit1 short packet |
| set_usb_err | output | 1 | Error counter exhausted |
| set_proc_err | output | 1 | Invalid PID seen |
| changed | output | 1 | Control word needs write-back |
| tok_pid | output | 8 | Decoded PID |
| tok_addr | output | 7 | Decoded device address |
| tok_ep | output | 4 | Decoded endpoint |
| tok_maxlen | output | 11 | Decoded maximum length |

## Verification
The block keeps no state between descriptors, so a wrong decision shows up in the output word registered at the edge that accepted the input. An error is visible within one cycle, in the same transaction that caused it. The mistakes most likely to reach the ports are these: an error count that wraps below zero, an active bit left set after exhaustion, and a clipped IN that writes a length. The random stimulus leans toward small error counts, counts near the maximum length, and the NAK-on-SETUP crossover, so that these mistakes show up.

// File: rtl/tdsu_pkg.sv
`timescale 1ns/1ps
package tdsu_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 11;

  // control word bit positions
  localparam int B_SPD   = 29;
  localparam int B_EHI   = 28;
  localparam int B_ELO   = 27;
  localparam int B_ISO   = 25;
  localparam int B_IOC   = 24;
  localparam int B_ACT   = 23;
  localparam int B_STALL = 22;
  localparam int B_BAB   = 20;
  localparam int B_NAK   = 19;
  localparam int B_TOUT  = 18;

  localparam logic [7:0] PID_SETUP = 8'h2D;
  localparam logic [7:0] PID_IN    = 8'h69;
  localparam logic [7:0] PID_OUT   = 8'hE1;

  localparam logic [2:0] RSP_DATA   = 3'd0;
  localparam logic [2:0] RSP_NODEV  = 3'd1;
  localparam logic [2:0] RSP_NAK    = 3'd2;
  localparam logic [2:0] RSP_STALL  = 3'd3;
  localparam logic [2:0] RSP_BABBLE = 3'd4;
  localparam logic [2:0] RSP_TOUT   = 3'd5;

  localparam logic [1:0] RES_OK    = 2'd0;
  localparam logic [1:0] RES_SKIP  = 2'd1;
  localparam logic [1:0] RES_ABORT = 2'd2;

  typedef struct packed {
    logic [7:0]       pid;
    logic [6:0]       addr;
    logic [3:0]       ep;
    logic [LEN_W-1:0] maxlen;
  } tok_t;

  typedef struct packed {
    logic [WORD_W-1:0] ctrl;
    logic [1:0]        res;
    logic [1:0]        cause;
    logic              usb_err;
    logic              proc_err;
    logic              chg;
  } upd_t;
endpackage

// File: rtl/tdsu_token_dec.sv
`timescale 1ns/1ps
module tdsu_token_dec
  import tdsu_pkg::*;
(
  input  logic [WORD_W-1:0] token,
  output tok_t              fields
);
  always_comb begin
    fields.pid    = token[7:0];
    fields.addr   = token[14:8];
    fields.ep     = token[18:15];
    fields.maxlen = token[31:21] + 11'd1;
  end
endmodule

// File: rtl/tdsu_retry.sv
`timescale 1ns/1ps
module tdsu_retry (
  input  logic [1:0] cnt_in,
  output logic [1:0] cnt_out,
  output logic       exhausted
);
  always_comb begin
    cnt_out   = (cnt_in == 2'd0) ? 2'd0 : cnt_in - 2'd1;
    exhausted = (cnt_in == 2'd1);
  end
endmodule

// File: rtl/tdsu_eval.sv
`timescale 1ns/1ps
module tdsu_eval
  import tdsu_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic [WORD_W-1:0] ctrl,
  input  tok_t              tok,
  input  logic [2:0]        rsp,
  input  logic [CNT_W-1:0]  count,
  output upd_t              upd
);
  logic             is_in, is_setup, pid_ok, over, to_path;
  logic [2:0]       eff;
  logic [LEN_W-1:0] len;
  logic [1:0]       ecnt_nxt;
  logic             ecnt_zero;

  tdsu_retry u_retry (
    .cnt_in    (ctrl[B_EHI:B_ELO]),
    .cnt_out   (ecnt_nxt),
    .exhausted (ecnt_zero)
  );

  always_comb begin
    is_in    = (tok.pid == PID_IN);
    is_setup = (tok.pid == PID_SETUP);
    pid_ok   = is_in || is_setup || (tok.pid == PID_OUT);
    over     = is_in && (rsp == RSP_DATA) && (count > CNT_W'(tok.maxlen));
    eff      = over ? RSP_BABBLE : rsp;
    len      = is_in ? count[LEN_W-1:0] : tok.maxlen;
    to_path  = 1'b0;

    upd.ctrl     = ctrl;
    upd.res      = RES_SKIP;
    upd.cause    = {1'b0, ctrl[B_IOC]};
    upd.usb_err  = 1'b0;
    upd.proc_err = 1'b0;

    if (ctrl[B_ACT]) begin
      if (!pid_ok) begin
        upd.proc_err = 1'b1;
        upd.res      = RES_ABORT;
      end else begin
        if (ctrl[B_ISO]) upd.ctrl[B_ACT] = 1'b0;
        case (eff)
          RSP_DATA: begin
            upd.ctrl[LEN_W-1:0] = len - 11'd1;
            upd.ctrl[B_ACT]     = 1'b0;
            if (is_in && ctrl[B_SPD] && (len < tok.maxlen)) begin
              upd.cause[1] = 1'b1;
              upd.res      = RES_SKIP;
            end else begin
              upd.res      = RES_OK;
            end
          end
          RSP_NAK: begin
            upd.ctrl[B_NAK] = 1'b1;
            to_path         = is_setup;
          end
          RSP_STALL: begin
            upd.ctrl[B_STALL] = 1'b1;
            upd.ctrl[B_ACT]   = 1'b0;
          end
          RSP_BABBLE: begin
            upd.ctrl[B_BAB]   = 1'b1;
            upd.ctrl[B_STALL] = 1'b1;
            upd.ctrl[B_ACT]   = 1'b0;
            upd.res           = RES_ABORT;
          end
          default: to_path = 1'b1;
        endcase
        if (to_path) begin
          upd.ctrl[B_TOUT]        = 1'b1;
          upd.ctrl[B_EHI:B_ELO]   = ecnt_nxt;
          if (ecnt_zero) begin
            upd.ctrl[B_ACT] = 1'b0;
            upd.usb_err     = 1'b1;
          end
        end
      end
    end
    upd.chg = (upd.ctrl != ctrl);
  end
endmodule

// File: rtl/td_status_unit.sv
`timescale 1ns/1ps
module td_status_unit
  import tdsu_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      ctrl_in,
  input  logic [31:0]      token_in,
  input  logic [2:0]       rsp_code,
  input  logic [CNT_W-1:0] rsp_count,
  output logic             out_valid,
  output logic [31:0]      ctrl_out,
  output logic [1:0]       result,
  output logic [1:0]       cause,
  output logic             set_usb_err,
  output logic             set_proc_err,
  output logic             changed,
  output logic [7:0]       tok_pid,
  output logic [6:0]       tok_addr,
  output logic [3:0]       tok_ep,
  output logic [10:0]      tok_maxlen
);
  tok_t tok_d, tok_q;
  upd_t upd_d, upd_q;
  logic vld_q;

  tdsu_token_dec u_dec (.token(token_in), .fields(tok_d));

  tdsu_eval #(.CNT_W(CNT_W)) u_eval (
    .ctrl  (ctrl_in),
    .tok   (tok_d),
    .rsp   (rsp_code),
    .count (rsp_count),
    .upd   (upd_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      tok_q <= '0;
      upd_q <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        tok_q <= tok_d;
        upd_q <= upd_d;
      end
    end
  end

  assign out_valid    = vld_q;
  assign ctrl_out     = upd_q.ctrl;
  assign result       = upd_q.res;
  assign cause        = upd_q.cause;
  assign set_usb_err  = upd_q.usb_err;
  assign set_proc_err = upd_q.proc_err;
  assign changed      = upd_q.chg;
  assign tok_pid      = tok_q.pid;
  assign tok_addr     = tok_q.addr;
  assign tok_ep       = tok_q.ep;
  assign tok_maxlen   = tok_q.maxlen;

  // R2: one accepted word yields one valid output cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(in_valid)));
  // R3: inactive descriptors pass through as skip
  a_r3_inactive_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ctrl_in[B_ACT]) |=>
      (result == RES_SKIP && ctrl_out == $past(ctrl_in) && !changed && !set_usb_err));
  // R3: completion cause tracks bit 24
  a_r3_ioc_cause: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (cause[0] == $past(ctrl_in[B_IOC])));
  // R4: process error aborts without touching the word
  a_r4_perr_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && set_proc_err) |-> (result == RES_ABORT && !changed));
  // R8: exhausted counter leaves descriptor retired
  a_r8_err_retires: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && set_usb_err) |->
      (!ctrl_out[B_ACT] && ctrl_out[B_EHI:B_ELO] == 2'd0 && ctrl_out[B_TOUT]));
  // R10: babble response aborts with stall marked
  a_r10_babble_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ctrl_in[B_ACT] && rsp_code == RSP_BABBLE &&
     (token_in[7:0] == PID_IN || token_in[7:0] == PID_OUT || token_in[7:0] == PID_SETUP)) |=>
      (result == RES_ABORT && ctrl_out[B_STALL] && ctrl_out[B_BAB] && !ctrl_out[B_ACT]));
  // R12: write-back flag matches a real difference
  a_r12_changed: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (changed == (ctrl_out != $past(ctrl_in))));
endmodule

// File: tb/sim_td_status_unit.sv
`timescale 1ns/1ps
module sim_td_status_unit;
  localparam int CW = 12;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [31:0] ctrl_in, token_in;
  logic [2:0]  rsp_code;
  logic [CW-1:0] rsp_count;
  logic out_valid, set_usb_err, set_proc_err, changed;
  logic [31:0] ctrl_out;
  logic [1:0] result, cause;
  logic [7:0] tok_pid;
  logic [6:0] tok_addr;
  logic [3:0] tok_ep;
  logic [10:0] tok_maxlen;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  td_status_unit #(.CNT_W(CW)) u0 (
    .clk, .rst_n, .in_valid, .ctrl_in, .token_in, .rsp_code, .rsp_count,
    .out_valid, .ctrl_out, .result, .cause, .set_usb_err, .set_proc_err,
    .changed, .tok_pid, .tok_addr, .tok_ep, .tok_maxlen);

  // expected bundle: {changed, proc_err, usb_err, cause, result, ctrl}
  function automatic logic [38:0] model(input logic [31:0] c, input logic [31:0] t,
                                        input logic [2:0] k, input logic [CW-1:0] n);
    logic [31:0] o; logic [1:0] r, ca; logic ue, pe, tp; logic [10:0] ml; logic [7:0] p;
    int ln;
    o = c; r = 2'd1; ca = {1'b0, c[24]}; ue = 0; pe = 0; tp = 0;
    ml = t[31:21] + 11'd1; p = t[7:0];
    if (c[23]) begin
      if (p != 8'h2D && p != 8'h69 && p != 8'hE1) begin pe = 1; r = 2'd2; end
      else begin
        if (c[25]) o[23] = 0;
        if (k == 3'd0) begin
          if (p == 8'h69 && int'(n) > int'(ml)) begin
            o[20] = 1; o[22] = 1; o[23] = 0; r = 2'd2;
          end else begin
            ln = (p == 8'h69) ? int'(n) : int'(ml);
            o[10:0] = 11'(ln - 1); o[23] = 0;
            if (p == 8'h69 && c[29] && ln < int'(ml)) begin ca[1] = 1; r = 2'd1; end
            else r = 2'd0;
          end
        end else if (k == 3'd2) begin o[19] = 1; tp = (p == 8'h2D); end
        else if (k == 3'd3) begin o[22] = 1; o[23] = 0; end
        else if (k == 3'd4) begin o[20] = 1; o[22] = 1; o[23] = 0; r = 2'd2; end
        else tp = 1;
        if (tp) begin
          o[18] = 1;
          if (c[28:27] != 2'd0) begin
            o[28:27] = c[28:27] - 2'd1;
            if (c[28:27] == 2'd1) begin o[23] = 0; ue = 1; end
          end
        end
      end
    end
    return {o != c, pe, ue, ca, r, o};
  endfunction

  function automatic string tag_of(input logic [31:0] c, input logic [31:0] t,
                                   input logic [2:0] k);
    if (!c[23]) return "R3";
    if (t[7:0] != 8'h2D && t[7:0] != 8'h69 && t[7:0] != 8'hE1) return "R4";
    if (c[25]) return "R11";
    case (k)
      3'd0: return (t[7:0] == 8'h69) ? "R6/R7" : "R5";
      3'd2: return "R9";
      3'd3, 3'd4: return "R10";
      default: return "R8";
    endcase
  endfunction

  task automatic apply(input logic [31:0] c, input logic [31:0] t,
                       input logic [2:0] k, input logic [CW-1:0] n, input string tg);
    logic [38:0] exp_v, act_v;
    logic [10:0] eml;
    @(negedge clk);
    ctrl_in = c; token_in = t; rsp_code = k; rsp_count = n; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    exp_v = model(c, t, k, n);
    act_v = {changed, set_proc_err, set_usb_err, cause, result, ctrl_out};
    checks++;
    if (!out_valid || act_v !== exp_v) begin
      errors++;
      $display("FAIL %s R12 bundle: act=%h vld=%b exp=%h (ctrl=%h tok=%h rsp=%0d cnt=%0d)",
               tg, act_v, out_valid, exp_v, c, t, k, n);
    end
    eml = t[31:21] + 11'd1;
    checks++;
    if ({tok_pid, tok_addr, tok_ep, tok_maxlen} !== {t[7:0], t[14:8], t[18:15], eml}) begin
      errors++;
      $display("FAIL R1 token: act=%h exp=%h", {tok_pid, tok_addr, tok_ep, tok_maxlen},
               {t[7:0], t[14:8], t[18:15], eml});
    end
  endtask

  function automatic logic [31:0] mk_tok(input logic [7:0] p, input logic [10:0] mlf);
    return {mlf, 2'b01, 4'h5, 7'h3A, p};
  endfunction

  initial begin
    logic [31:0] c, t; logic [7:0] p; logic [2:0] k; logic [CW-1:0] n;
    logic [31:0] hold;
    void'($urandom(32'd1234));
    rst_n = 1'b0; in_valid = 0; ctrl_in = 0; token_in = 0; rsp_code = 0; rsp_count = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || ctrl_out !== 32'd0 || result !== 2'd0) begin
      errors++; $display("FAIL R2 reset: vld=%b ctrl=%h res=%0d exp 0", out_valid, ctrl_out, result);
    end
    rst_n = 1'b1;
    // directed corner cases
    apply(32'h0100_0000, mk_tok(8'h69, 11'd7), 3'd0, 12'd3, "R3");          // inactive with IOC
    apply(32'h0080_0000, mk_tok(8'h55, 11'd7), 3'd0, 12'd3, "R4");          // bad PID
    apply(32'h0080_0000, mk_tok(8'hE1, 11'd7), 3'd0, 12'd0, "R5");          // OUT success len 8
    apply(32'h0080_0000, mk_tok(8'h2D, 11'h7FF), 3'd0, 12'd0, "R5");        // null packet, maxlen 0
    apply(32'h0080_0000, mk_tok(8'h69, 11'd7), 3'd0, 12'd9, "R6");          // over-count
    apply(32'h2080_0000, mk_tok(8'h69, 11'd7), 3'd0, 12'd4, "R7");          // short packet
    apply(32'h2080_0000, mk_tok(8'h69, 11'd7), 3'd0, 12'd8, "R7");          // exact, not short
    apply(32'h1880_0000, mk_tok(8'hE1, 11'd7), 3'd1, 12'd0, "R8");          // count 3 -> 2
    apply(32'h0880_0000, mk_tok(8'hE1, 11'd7), 3'd5, 12'd0, "R8");          // count 1 -> exhausted
    apply(32'h0080_0000, mk_tok(8'hE1, 11'd7), 3'd7, 12'd0, "R8");          // count 0 stays
    apply(32'h1080_0000, mk_tok(8'h69, 11'd7), 3'd2, 12'd0, "R9");          // NAK on IN
    apply(32'h0880_0000, mk_tok(8'h2D, 11'd7), 3'd2, 12'd0, "R9");          // NAK on SETUP
    apply(32'h0080_0000, mk_tok(8'hE1, 11'd7), 3'd3, 12'd0, "R10");
    apply(32'h0080_0000, mk_tok(8'hE1, 11'd7), 3'd4, 12'd0, "R10");
    apply(32'h0280_0000, mk_tok(8'h69, 11'd7), 3'd2, 12'd0, "R11");         // ISO clears on NAK
    // hold check: outputs keep last value with no new word
    hold = ctrl_out;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || ctrl_out !== hold) begin
      errors++; $display("FAIL R2 hold: vld=%b ctrl=%h exp 0 %h", out_valid, ctrl_out, hold);
    end
    // constrained random
    for (int i = 0; i < 400; i++) begin
      c = $urandom();
      if ($urandom_range(3) != 0) c[23] = 1'b1;
      case ($urandom_range(9))
        0: p = 8'($urandom());
        1, 2, 3: p = 8'h69;
        4, 5: p = 8'h2D;
        default: p = 8'hE1;
      endcase
      t = $urandom();
      t[7:0] = p;
      if ($urandom_range(1) == 1) t[31:21] = 11'($urandom_range(15));
      k = 3'($urandom_range(7));
      if ($urandom_range(1) == 1) k = 3'd0;
      n = CW'($urandom_range(20));
      if ($urandom_range(3) == 0) n = CW'(t[31:21]) + CW'($urandom_range(2));
      apply(c, t, k, n, tag_of(c, t, k));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule